// File: doc/BRIEF.md
# Bound register move unit

This block executes the bound-move instruction of a small processor model. It keeps a file of bound registers, each holding a 64-bit lower bound and a 64-bit upper bound. It takes an instruction that has already been decoded: the opcode byte, the operand-size and lock prefix flags, the ModRM fields, the two REX extension bits, the operating mode and a ready effective address. From these it copies a bound pair from one register to another, or between a register and memory.

Memory traffic goes through a single-beat request/response port. The lower bound always moves first and the upper bound second. A beat is 64 bits wide in 64-bit mode and 32 bits wide otherwise. Invalid-opcode conditions are detected at decode and end the instruction without any memory traffic. A fault that the caller flags on a memory response aborts the instruction. In both cases the destination register is left untouched. The flags word is passed straight through, because the instruction changes no flags. A combinational read port makes any bound register visible to neighbouring logic.

Top module: `bnd_move_unit`

## Requirements
- R1: After reset every bound register reads zero, and `done_o`, `busy_o` and `mem_req_o` are low.
- R2: With `mod_i`=3, opcode 0x1A copies both bounds of register `rm` into register `reg`, and opcode 0x1B copies register `reg` into register `rm`. `done_o` pulses with code 0 in the cycle after the start cycle, and the new value can be read from then on.
- R3: A 64-bit-mode load (0x1A, `mod_i`≠3) issues two read beats with `mem_size_o`=1. The first is at `ea_i` for the lower bound and the second at `ea_i`+8 for the upper bound. The register is written, and `done_o` pulses, in the cycle after the second response.
- R4: Outside 64-bit mode a load issues reads at `ea_i` and `ea_i`+4 with `mem_size_o`=0. Only bits 31:0 of each response are kept, zero-extended to 64 bits.
- R5: A 64-bit-mode store (0x1B, `mod_i`≠3) writes the lower bound at `ea_i` and then the upper bound at `ea_i`+8, with `mem_we_o`=1 and `mem_size_o`=1.
- R6: Outside 64-bit mode a store writes bits 31:0 of the lower bound at `ea_i` and then bits 31:0 of the upper bound at `ea_i`+4. Bits 63:32 of `mem_wdata_o` are zero on both beats.
- R7: The lock flag gives an invalid-opcode fault (code 1) when the destination is a register, that is, on any 0x1A or on 0x1B with `mod_i`=3. A locked 0x1B to memory executes normally.
- R8: A register operand index of 4 or higher gives code 1. The reg index is {`rex_r_i`,`reg_i`}, and the rm index is {`rex_b_i`,`rm_i`}, checked only when `mod_i`=3. The REX bits count only in 64-bit mode.
- R9: An opcode other than 0x1A/0x1B, or a missing 0x66 prefix flag, gives code 1.
- R10: `mem_fault_i` on a response ends the instruction: `done_o` pulses next cycle with code 2, no further beat is issued and the destination register keeps its old value.
- R11: `flags_o` equals `flags_i` at all times.
- R12: An invalid-opcode fault pulses `done_o` in the cycle after start with no memory request and no register write. `done_o` lasts one cycle. `start_i` is ignored while `busy_o` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Instruction valid, accepted when idle |
| opcode_i | input | 8 | Opcode byte after the 0x0F escape |
| pfx_opsz_i | input | 1 | 0x66 prefix present |
| pfx_lock_i | input | 1 | Lock prefix present |
| mod_i | input | 2 | ModRM mod field |
| reg_i | input | 3 | ModRM reg field |
| rm_i | input | 3 | ModRM r/m field |
| rex_r_i | input | 1 | REX extension of reg |
| rex_b_i | input | 1 | REX extension of r/m |
| mode64_i | input | 1 | 64-bit mode |
| ea_i | input | 64 | Effective address |
| flags_i | input | 32 | Flags in |
| flags_o | output | 32 | Flags out, unchanged |
| mem_req_o | output | 1 | Memory beat request, held until response |
| mem_we_o | output | 1 | Beat is a write |
| mem_size_o | output | 1 | 1: 64-bit beat, 0: 32-bit beat |
| mem_addr_o | output | 64 | Beat address |
| mem_wdata_o | output | 64 | Write data |
| mem_rsp_valid_i | input | 1 | Response for the current beat |
| mem_rdata_i | input | 64 | Read data |
| mem_fault_i | input | 1 | Response carries a fault |
| done_o | output | 1 | Instruction finished |
| fault_code_o | output | 2 | 0 none, 1 invalid opcode, 2 memory fault; valid with done_o |
| busy_o | output | 1 | Instruction in progress |
| rd_idx_i | input | 2 | Read port register index |
| rd_lb_o | output | 64 | Lower bound of register rd_idx_i |
| rd_ub_o | output | 64 | Upper bound of register rd_idx_i |

## Verification
The hardest case to reach is a memory fault on the second beat of a load. By that point the lower bound has already been captured, and it must be thrown away. The bench gets there with a load whose r/m field carries a REX bit that would be illegal for a register operand but is harmless for memory. It answers the first beat cleanly and flags the second, then reads the register back. A second case is a start pulse that arrives while a load waits for its first response. The bench drives a register move in that window and confirms that the move leaves no trace.

// File: rtl/bnd_pkg.sv
package bnd_pkg;
  localparam logic [7:0] OPC_LOAD  = 8'h1A;
  localparam logic [7:0] OPC_STORE = 8'h1B;

  typedef enum logic [1:0] {
    FC_NONE = 2'd0,
    FC_UD   = 2'd1,
    FC_MEM  = 2'd2
  } fault_code_e;

  typedef enum logic [1:0] {
    S_IDLE = 2'd0,
    S_LO   = 2'd1,
    S_HI   = 2'd2,
    S_FIN  = 2'd3
  } seq_state_e;
endpackage

// File: rtl/bnd_decode.sv
module bnd_decode
  import bnd_pkg::*;
#(
  parameter int NUM_BND = 4,
  localparam int IDX_W  = $clog2(NUM_BND)
) (
  input  logic [7:0]       opcode_i,
  input  logic             pfx_opsz_i,
  input  logic             pfx_lock_i,
  input  logic [1:0]       mod_i,
  input  logic [2:0]       reg_i,
  input  logic [2:0]       rm_i,
  input  logic             rex_r_i,
  input  logic             rex_b_i,
  input  logic             mode64_i,
  output logic             is_load_o,
  output logic             use_mem_o,
  output logic             ud_o,
  output logic [IDX_W-1:0] src_idx_o,
  output logic [IDX_W-1:0] dst_idx_o
);
  localparam logic [3:0] NUM_L = 4'(NUM_BND);

  logic [3:0] raw_reg, raw_rm;
  logic       opc_ok, reg_bad, rm_bad, lock_bad;

  always_comb begin
    raw_reg   = {mode64_i & rex_r_i, reg_i};
    raw_rm    = {mode64_i & rex_b_i, rm_i};
    is_load_o = (opcode_i == OPC_LOAD);
    use_mem_o = (mod_i != 2'b11);
    opc_ok    = pfx_opsz_i && ((opcode_i == OPC_LOAD) || (opcode_i == OPC_STORE));
    reg_bad   = (raw_reg >= NUM_L);
    rm_bad    = !use_mem_o && (raw_rm >= NUM_L);
    // load always targets a register; store targets one only when mod==3
    lock_bad  = pfx_lock_i && (is_load_o || !use_mem_o);
    ud_o      = !opc_ok || reg_bad || rm_bad || lock_bad;
    if (is_load_o) begin
      dst_idx_o = raw_reg[IDX_W-1:0];
      src_idx_o = raw_rm[IDX_W-1:0];
    end else begin
      dst_idx_o = raw_rm[IDX_W-1:0];
      src_idx_o = raw_reg[IDX_W-1:0];
    end
  end
endmodule

// File: rtl/bnd_regfile.sv
module bnd_regfile #(
  parameter int NUM_BND = 4,
  parameter int BND_W   = 64,
  localparam int IDX_W  = $clog2(NUM_BND)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [IDX_W-1:0] widx_i,
  input  logic [BND_W-1:0] wlb_i,
  input  logic [BND_W-1:0] wub_i,
  input  logic [IDX_W-1:0] ra_idx_i,
  output logic [BND_W-1:0] ra_lb_o,
  output logic [BND_W-1:0] ra_ub_o,
  input  logic [IDX_W-1:0] rb_idx_i,
  output logic [BND_W-1:0] rb_lb_o,
  output logic [BND_W-1:0] rb_ub_o
);
  logic [BND_W-1:0] lb_q [NUM_BND];
  logic [BND_W-1:0] ub_q [NUM_BND];

  for (genvar i = 0; i < NUM_BND; i++) begin : g_entry
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        lb_q[i] <= '0;
        ub_q[i] <= '0;
      end else if (we_i && (widx_i == IDX_W'(i))) begin
        lb_q[i] <= wlb_i;
        ub_q[i] <= wub_i;
      end
    end
  end

  assign ra_lb_o = lb_q[ra_idx_i];
  assign ra_ub_o = ub_q[ra_idx_i];
  assign rb_lb_o = lb_q[rb_idx_i];
  assign rb_ub_o = ub_q[rb_idx_i];
endmodule

// File: rtl/bnd_seq.sv
module bnd_seq
  import bnd_pkg::*;
#(
  parameter int NUM_BND = 4,
  parameter int BND_W   = 64,
  parameter int ADDR_W  = 64,
  localparam int IDX_W  = $clog2(NUM_BND),
  localparam int HALF_W = BND_W / 2,
  localparam int STEP64 = BND_W / 8,
  localparam int STEP32 = HALF_W / 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              is_load_i,
  input  logic              use_mem_i,
  input  logic              ud_i,
  input  logic [IDX_W-1:0]  dst_idx_i,
  input  logic              mode64_i,
  input  logic [ADDR_W-1:0] ea_i,
  input  logic [BND_W-1:0]  src_lb_i,
  input  logic [BND_W-1:0]  src_ub_i,
  output logic              reg_we_o,
  output logic [IDX_W-1:0]  reg_widx_o,
  output logic [BND_W-1:0]  reg_wlb_o,
  output logic [BND_W-1:0]  reg_wub_o,
  output logic              mem_req_o,
  output logic              mem_we_o,
  output logic              mem_size_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [BND_W-1:0]  mem_wdata_o,
  input  logic              mem_rsp_valid_i,
  input  logic [BND_W-1:0]  mem_rdata_i,
  input  logic              mem_fault_i,
  output logic              done_o,
  output logic [1:0]        fault_code_o,
  output logic              busy_o
);
  seq_state_e        state_q;
  logic              load_q, m64_q;
  logic [IDX_W-1:0]  dst_q;
  logic [ADDR_W-1:0] addr_q;
  logic [BND_W-1:0]  tmp_lb_q, tmp_ub_q;
  fault_code_e       code_q;

  logic             accept, reg_move, rsp_ok, rsp_bad;
  logic [BND_W-1:0] rdata_ext, beat_data;

  assign accept   = (state_q == S_IDLE) && start_i;
  assign reg_move = accept && !ud_i && !use_mem_i;
  assign rsp_ok   = mem_req_o && mem_rsp_valid_i && !mem_fault_i;
  assign rsp_bad  = mem_req_o && mem_rsp_valid_i && mem_fault_i;

  assign rdata_ext = m64_q ? mem_rdata_i : {{(BND_W-HALF_W){1'b0}}, mem_rdata_i[HALF_W-1:0]};
  assign beat_data = (state_q == S_LO) ? tmp_lb_q : tmp_ub_q;

  always_comb begin
    reg_we_o   = 1'b0;
    reg_widx_o = dst_q;
    reg_wlb_o  = tmp_lb_q;
    reg_wub_o  = rdata_ext;
    if (reg_move) begin
      reg_we_o   = 1'b1;
      reg_widx_o = dst_idx_i;
      reg_wlb_o  = src_lb_i;
      reg_wub_o  = src_ub_i;
    end else if ((state_q == S_HI) && rsp_ok && load_q) begin
      reg_we_o = 1'b1;
    end
  end

  always_comb begin
    mem_req_o   = (state_q == S_LO) || (state_q == S_HI);
    mem_we_o    = mem_req_o && !load_q;
    mem_size_o  = m64_q;
    mem_addr_o  = addr_q;
    if (state_q == S_HI)
      mem_addr_o = addr_q + (m64_q ? ADDR_W'(STEP64) : ADDR_W'(STEP32));
    mem_wdata_o = '0;
    if (mem_we_o)
      mem_wdata_o = m64_q ? beat_data : {{(BND_W-HALF_W){1'b0}}, beat_data[HALF_W-1:0]};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= S_IDLE;
      load_q   <= 1'b0;
      m64_q    <= 1'b0;
      dst_q    <= '0;
      addr_q   <= '0;
      tmp_lb_q <= '0;
      tmp_ub_q <= '0;
      code_q   <= FC_NONE;
    end else begin
      unique case (state_q)
        S_IDLE: if (start_i) begin
          load_q   <= is_load_i;
          m64_q    <= mode64_i;
          dst_q    <= dst_idx_i;
          addr_q   <= ea_i;
          tmp_lb_q <= src_lb_i;
          tmp_ub_q <= src_ub_i;
          if (ud_i) begin
            code_q  <= FC_UD;
            state_q <= S_FIN;
          end else if (!use_mem_i) begin
            code_q  <= FC_NONE;
            state_q <= S_FIN;
          end else begin
            code_q  <= FC_NONE;
            state_q <= S_LO;
          end
        end
        S_LO: begin
          if (rsp_bad) begin
            code_q  <= FC_MEM;
            state_q <= S_FIN;
          end else if (rsp_ok) begin
            if (load_q) tmp_lb_q <= rdata_ext;
            state_q <= S_HI;
          end
        end
        S_HI: begin
          if (rsp_bad) begin
            code_q  <= FC_MEM;
            state_q <= S_FIN;
          end else if (rsp_ok) begin
            state_q <= S_FIN;
          end
        end
        S_FIN: state_q <= S_IDLE;
        default: state_q <= S_IDLE;
      endcase
    end
  end

  assign done_o       = (state_q == S_FIN);
  assign fault_code_o = done_o ? code_q : FC_NONE;
  assign busy_o       = (state_q != S_IDLE);
endmodule

// File: rtl/bnd_move_unit.sv
module bnd_move_unit #(
  parameter int NUM_BND = 4,
  parameter int BND_W   = 64,
  parameter int ADDR_W  = 64,
  parameter int FLAGS_W = 32,
  localparam int IDX_W  = $clog2(NUM_BND)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               start_i,
  input  logic [7:0]         opcode_i,
  input  logic               pfx_opsz_i,
  input  logic               pfx_lock_i,
  input  logic [1:0]         mod_i,
  input  logic [2:0]         reg_i,
  input  logic [2:0]         rm_i,
  input  logic               rex_r_i,
  input  logic               rex_b_i,
  input  logic               mode64_i,
  input  logic [ADDR_W-1:0]  ea_i,
  input  logic [FLAGS_W-1:0] flags_i,
  output logic [FLAGS_W-1:0] flags_o,
  output logic               mem_req_o,
  output logic               mem_we_o,
  output logic               mem_size_o,
  output logic [ADDR_W-1:0]  mem_addr_o,
  output logic [BND_W-1:0]   mem_wdata_o,
  input  logic               mem_rsp_valid_i,
  input  logic [BND_W-1:0]   mem_rdata_i,
  input  logic               mem_fault_i,
  output logic               done_o,
  output logic [1:0]         fault_code_o,
  output logic               busy_o,
  input  logic [IDX_W-1:0]   rd_idx_i,
  output logic [BND_W-1:0]   rd_lb_o,
  output logic [BND_W-1:0]   rd_ub_o
);
  logic             is_load, use_mem, ud;
  logic [IDX_W-1:0] src_idx, dst_idx;
  logic             reg_we;
  logic [IDX_W-1:0] reg_widx;
  logic [BND_W-1:0] reg_wlb, reg_wub, src_lb, src_ub;

  assign flags_o = flags_i;

  bnd_decode #(.NUM_BND(NUM_BND)) u_dec (
    .opcode_i   (opcode_i),
    .pfx_opsz_i (pfx_opsz_i),
    .pfx_lock_i (pfx_lock_i),
    .mod_i      (mod_i),
    .reg_i      (reg_i),
    .rm_i       (rm_i),
    .rex_r_i    (rex_r_i),
    .rex_b_i    (rex_b_i),
    .mode64_i   (mode64_i),
    .is_load_o  (is_load),
    .use_mem_o  (use_mem),
    .ud_o       (ud),
    .src_idx_o  (src_idx),
    .dst_idx_o  (dst_idx)
  );

  bnd_regfile #(.NUM_BND(NUM_BND), .BND_W(BND_W)) u_rf (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .we_i     (reg_we),
    .widx_i   (reg_widx),
    .wlb_i    (reg_wlb),
    .wub_i    (reg_wub),
    .ra_idx_i (src_idx),
    .ra_lb_o  (src_lb),
    .ra_ub_o  (src_ub),
    .rb_idx_i (rd_idx_i),
    .rb_lb_o  (rd_lb_o),
    .rb_ub_o  (rd_ub_o)
  );

  bnd_seq #(.NUM_BND(NUM_BND), .BND_W(BND_W), .ADDR_W(ADDR_W)) u_seq (
    .clk_i           (clk_i),
    .rst_ni          (rst_ni),
    .start_i         (start_i),
    .is_load_i       (is_load),
    .use_mem_i       (use_mem),
    .ud_i            (ud),
    .dst_idx_i       (dst_idx),
    .mode64_i        (mode64_i),
    .ea_i            (ea_i),
    .src_lb_i        (src_lb),
    .src_ub_i        (src_ub),
    .reg_we_o        (reg_we),
    .reg_widx_o      (reg_widx),
    .reg_wlb_o       (reg_wlb),
    .reg_wub_o       (reg_wub),
    .mem_req_o       (mem_req_o),
    .mem_we_o        (mem_we_o),
    .mem_size_o      (mem_size_o),
    .mem_addr_o      (mem_addr_o),
    .mem_wdata_o     (mem_wdata_o),
    .mem_rsp_valid_i (mem_rsp_valid_i),
    .mem_rdata_i     (mem_rdata_i),
    .mem_fault_i     (mem_fault_i),
    .done_o          (done_o),
    .fault_code_o    (fault_code_o),
    .busy_o          (busy_o)
  );
endmodule

// File: rtl/bnd_move_chk.sv
module bnd_move_chk #(
  parameter int BND_W  = 64,
  parameter int ADDR_W = 64
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              done_i,
  input logic [1:0]        fault_code_i,
  input logic              busy_i,
  input logic              mem_req_i,
  input logic              mem_we_i,
  input logic              mem_size_i,
  input logic [ADDR_W-1:0] mem_addr_i,
  input logic [BND_W-1:0]  mem_wdata_i,
  input logic              mem_rsp_valid_i,
  input logic              mem_fault_i,
  input logic              reg_we_i
);
  localparam int HALF_W = BND_W / 2;

  assert_done_pulse_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_i |=> !done_i);

  assert_req_busy_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_i |-> busy_i);

  assert_ud_no_write_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_i && fault_code_i == 2'd1) |-> $past(!reg_we_i && !mem_req_i));

  assert_fault_no_write_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_i && mem_rsp_valid_i && mem_fault_i) |-> !reg_we_i);

  assert_fault_ends_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_i && mem_rsp_valid_i && mem_fault_i) |=> (done_i && fault_code_i == 2'd2));

  assert_store32_upper_zero_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_i && mem_we_i && !mem_size_i) |-> (mem_wdata_i[BND_W-1:HALF_W] == '0));

  assert_second_addr_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_i && mem_rsp_valid_i && !mem_fault_i) ##1 mem_req_i |->
      mem_addr_i == $past(mem_addr_i) + (mem_size_i ? ADDR_W'(8) : ADDR_W'(4)));

  assert_req_held_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_i && !mem_rsp_valid_i) |=> (mem_req_i && $stable(mem_addr_i)));
endmodule

bind bnd_move_unit bnd_move_chk #(.BND_W(BND_W), .ADDR_W(ADDR_W)) u_chk (
  .clk_i           (clk_i),
  .rst_ni          (rst_ni),
  .done_i          (done_o),
  .fault_code_i    (fault_code_o),
  .busy_i          (busy_o),
  .mem_req_i       (mem_req_o),
  .mem_we_i        (mem_we_o),
  .mem_size_i      (mem_size_o),
  .mem_addr_i      (mem_addr_o),
  .mem_wdata_i     (mem_wdata_o),
  .mem_rsp_valid_i (mem_rsp_valid_i),
  .mem_fault_i     (mem_fault_i),
  .reg_we_i        (reg_we)
);

// File: tb/bnd_move_unit_tb.sv
module bnd_move_unit_tb_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        start;
  logic [7:0]  opcode;
  logic        pfx_opsz, pfx_lock;
  logic [1:0]  mod_f;
  logic [2:0]  reg_f, rm_f;
  logic        rex_r, rex_b, mode64;
  logic [63:0] ea;
  logic [31:0] flags_in, flags_out;
  logic        mem_req, mem_we, mem_size;
  logic [63:0] mem_addr, mem_wdata;
  logic        rsp_valid, rsp_fault;
  logic [63:0] rsp_data;
  logic        done, busy;
  logic [1:0]  fcode;
  logic [1:0]  rd_idx;
  logic [63:0] rd_lb, rd_ub;

  int checks = 0;
  int errors = 0;
  bit finished = 0;
  logic [63:0] exp_lb [4];
  logic [63:0] exp_ub [4];

  always #4 clk = ~clk;

  bnd_move_unit dut_i (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .opcode_i(opcode),
    .pfx_opsz_i(pfx_opsz), .pfx_lock_i(pfx_lock), .mod_i(mod_f), .reg_i(reg_f),
    .rm_i(rm_f), .rex_r_i(rex_r), .rex_b_i(rex_b), .mode64_i(mode64), .ea_i(ea),
    .flags_i(flags_in), .flags_o(flags_out), .mem_req_o(mem_req), .mem_we_o(mem_we),
    .mem_size_o(mem_size), .mem_addr_o(mem_addr), .mem_wdata_o(mem_wdata),
    .mem_rsp_valid_i(rsp_valid), .mem_rdata_i(rsp_data), .mem_fault_i(rsp_fault),
    .done_o(done), .fault_code_o(fcode), .busy_o(busy),
    .rd_idx_i(rd_idx), .rd_lb_o(rd_lb), .rd_ub_o(rd_ub)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  // start on one edge; returns at the negedge after it
  task automatic issue(input logic [7:0] opc, input bit p66, input bit lock,
                       input logic [1:0] md, input logic [2:0] rg, input logic [2:0] rm,
                       input bit rr, input bit rb, input bit m64, input logic [63:0] a);
    opcode = opc; pfx_opsz = p66; pfx_lock = lock; mod_f = md; reg_f = rg; rm_f = rm;
    rex_r = rr; rex_b = rb; mode64 = m64; ea = a; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic beat(input string req, input logic [63:0] addr, input bit we, input bit sz,
                      input logic [63:0] wd, input logic [63:0] rdata, input bit flt);
    chk(mem_req === 1'b1, req, "mem_req", 64'(mem_req), 64'd1);
    chk(mem_addr === addr, req, "mem_addr", mem_addr, addr);
    chk(mem_we === we, req, "mem_we", 64'(mem_we), 64'(we));
    chk(mem_size === sz, req, "mem_size", 64'(mem_size), 64'(sz));
    if (we) chk(mem_wdata === wd, req, "mem_wdata", mem_wdata, wd);
    rsp_valid = 1'b1; rsp_data = rdata; rsp_fault = flt;
    @(negedge clk);
    rsp_valid = 1'b0; rsp_fault = 1'b0; rsp_data = '0;
  endtask

  task automatic expect_done(input string req, input logic [1:0] code);
    chk(done === 1'b1, req, "done", 64'(done), 64'd1);
    chk(fcode === code, req, "fault_code", 64'(fcode), 64'(code));
    chk(mem_req === 1'b0, req, "no mem_req at done", 64'(mem_req), 64'd0);
    @(negedge clk);
    chk(done === 1'b0 && busy === 1'b0, req, "idle after done", {62'd0, done, busy}, 64'd0);
  endtask

  task automatic check_reg(input string req, input int idx);
    rd_idx = 2'(idx);
    #1;
    chk(rd_lb === exp_lb[idx], req, $sformatf("bnd%0d lb", idx), rd_lb, exp_lb[idx]);
    chk(rd_ub === exp_ub[idx], req, $sformatf("bnd%0d ub", idx), rd_ub, exp_ub[idx]);
  endtask

  task automatic t_reset();
    for (int i = 0; i < 4; i++) begin exp_lb[i] = '0; exp_ub[i] = '0; check_reg("R1", i); end
    chk(done === 1'b0 && busy === 1'b0 && mem_req === 1'b0, "R1", "outputs after reset",
        {61'd0, done, busy, mem_req}, 64'd0);
  endtask

  task automatic t_load64();
    issue(8'h1A, 1, 0, 2'b00, 3'd0, 3'd5, 0, 0, 1, 64'h1000);
    beat("R3", 64'h1000, 0, 1, '0, 64'hA0A0_0001_0000_1111, 0);
    beat("R3", 64'h1008, 0, 1, '0, 64'hA1A1_0002_0000_2222, 0);
    exp_lb[0] = 64'hA0A0_0001_0000_1111; exp_ub[0] = 64'hA1A1_0002_0000_2222;
    expect_done("R3", 2'd0);
    check_reg("R3", 0);
    issue(8'h1A, 1, 0, 2'b10, 3'd1, 3'd0, 0, 1, 1, 64'hFFFF_FFFF_FFFF_FFF0);
    beat("R3", 64'hFFFF_FFFF_FFFF_FFF0, 0, 1, '0, 64'hB0B0_1234_5678_9ABC, 0);
    beat("R3", 64'hFFFF_FFFF_FFFF_FFF8, 0, 1, '0, 64'hB1B1_CAFE_F00D_0001, 0);
    exp_lb[1] = 64'hB0B0_1234_5678_9ABC; exp_ub[1] = 64'hB1B1_CAFE_F00D_0001;
    expect_done("R3", 2'd0);
    check_reg("R3", 1);
  endtask

  task automatic t_load32();
    // rex_r set outside 64-bit mode must be ignored (R8)
    issue(8'h1A, 1, 0, 2'b01, 3'd2, 3'd3, 1, 0, 0, 64'h300);
    beat("R4", 64'h300, 0, 0, '0, 64'hDEAD_BEEF_1234_5678, 0);
    beat("R4", 64'h304, 0, 0, '0, 64'hFFFF_FFFF_8765_4321, 0);
    exp_lb[2] = 64'h0000_0000_1234_5678; exp_ub[2] = 64'h0000_0000_8765_4321;
    expect_done("R8", 2'd0);
    check_reg("R4", 2);
  endtask

  task automatic t_regmove();
    issue(8'h1A, 1, 0, 2'b11, 3'd3, 3'd0, 0, 0, 1, 64'h0);
    exp_lb[3] = exp_lb[0]; exp_ub[3] = exp_ub[0];
    expect_done("R2", 2'd0);
    check_reg("R2", 3);
    issue(8'h1B, 1, 0, 2'b11, 3'd2, 3'd1, 0, 0, 0, 64'h0);
    exp_lb[1] = exp_lb[2]; exp_ub[1] = exp_ub[2];
    chk(done === 1'b1, "R2", "done one cycle after start", 64'(done), 64'd1);
    check_reg("R2", 1);
    expect_done("R2", 2'd0);
    check_reg("R2", 2);
  endtask

  task automatic t_store64();
    issue(8'h1B, 1, 0, 2'b00, 3'd3, 3'd6, 0, 0, 1, 64'h4000);
    beat("R5", 64'h4000, 1, 1, exp_lb[3], '0, 0);
    beat("R5", 64'h4008, 1, 1, exp_ub[3], '0, 0);
    expect_done("R5", 2'd0);
    check_reg("R5", 3);
  endtask

  task automatic t_store32();
    issue(8'h1B, 1, 0, 2'b10, 3'd0, 3'd4, 0, 0, 0, 64'h50);
    beat("R6", 64'h50, 1, 0, {32'd0, exp_lb[0][31:0]}, '0, 0);
    beat("R6", 64'h54, 1, 0, {32'd0, exp_ub[0][31:0]}, '0, 0);
    expect_done("R6", 2'd0);
  endtask

  task automatic t_lock();
    issue(8'h1A, 1, 1, 2'b00, 3'd0, 3'd0, 0, 0, 1, 64'h700);
    expect_done("R7", 2'd1);
    issue(8'h1B, 1, 1, 2'b11, 3'd0, 3'd3, 0, 0, 1, 64'h0);
    expect_done("R7", 2'd1);
    check_reg("R7", 3);
    issue(8'h1B, 1, 1, 2'b00, 3'd1, 3'd0, 0, 0, 1, 64'h800);
    beat("R7", 64'h800, 1, 1, exp_lb[1], '0, 0);
    beat("R7", 64'h808, 1, 1, exp_ub[1], '0, 0);
    expect_done("R7", 2'd0);
  endtask

  task automatic t_index();
    issue(8'h1A, 1, 0, 2'b11, 3'd4, 3'd0, 0, 0, 0, 64'h0);
    expect_done("R8", 2'd1);
    issue(8'h1A, 1, 0, 2'b00, 3'd0, 3'd0, 1, 0, 1, 64'h900);
    expect_done("R8", 2'd1);
    issue(8'h1B, 1, 0, 2'b11, 3'd0, 3'd2, 0, 1, 1, 64'h0);
    expect_done("R8", 2'd1);
    check_reg("R8", 0);
    check_reg("R8", 2);
  endtask

  task automatic t_fault();
    // rex_b on a memory operand is legal; fault on the second beat
    issue(8'h1A, 1, 0, 2'b00, 3'd2, 3'd7, 0, 1, 1, 64'hA00);
    beat("R10", 64'hA00, 0, 1, '0, 64'h5555_5555_5555_5555, 0);
    beat("R10", 64'hA08, 0, 1, '0, 64'h6666_6666_6666_6666, 1);
    expect_done("R10", 2'd2);
    check_reg("R10", 2);
    issue(8'h1A, 1, 0, 2'b00, 3'd3, 3'd0, 0, 0, 0, 64'hB00);
    beat("R10", 64'hB00, 0, 0, '0, 64'h7777_7777_7777_7777, 1);
    expect_done("R10", 2'd2);
    check_reg("R10", 3);
  endtask

  task automatic t_opcode();
    issue(8'h1C, 1, 0, 2'b11, 3'd0, 3'd1, 0, 0, 1, 64'h0);
    expect_done("R9", 2'd1);
    issue(8'h1A, 0, 0, 2'b11, 3'd0, 3'd1, 0, 0, 1, 64'h0);
    expect_done("R9", 2'd1);
    check_reg("R9", 0);
  endtask

  task automatic t_busy();
    issue(8'h1A, 1, 0, 2'b00, 3'd3, 3'd0, 0, 0, 1, 64'hC00);
    // move bnd1 -> bnd0 while the load waits: must be dropped
    opcode = 8'h1A; pfx_opsz = 1; pfx_lock = 0; mod_f = 2'b11; reg_f = 3'd0; rm_f = 3'd1;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(busy === 1'b1 && done === 1'b0, "R12", "still busy", {62'd0, busy, done}, 64'h2);
    mode64 = 1'b1; ea = 64'hC00;
    beat("R12", 64'hC00, 0, 1, '0, 64'h0123_4567_89AB_CDEF, 0);
    beat("R12", 64'hC08, 0, 1, '0, 64'hFEDC_BA98_7654_3210, 0);
    exp_lb[3] = 64'h0123_4567_89AB_CDEF; exp_ub[3] = 64'hFEDC_BA98_7654_3210;
    expect_done("R12", 2'd0);
    check_reg("R12", 0);
    check_reg("R12", 3);
  endtask

  task automatic t_flags();
    for (int i = 0; i < 4; i++) begin
      flags_in = 32'h1357_9BDF ^ (32'(i) * 32'h0F0F_1111);
      #1;
      chk(flags_out === flags_in, "R11", "flags pass", 64'(flags_out), 64'(flags_in));
      @(negedge clk);
    end
    issue(8'h1B, 1, 0, 2'b11, 3'd3, 3'd2, 0, 0, 1, 64'h0);
    exp_lb[2] = exp_lb[3]; exp_ub[2] = exp_ub[3];
    chk(flags_out === flags_in, "R11", "flags during move", 64'(flags_out), 64'(flags_in));
    expect_done("R11", 2'd0);
    check_reg("R11", 2);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    rst_n = 0; start = 0; opcode = '0; pfx_opsz = 0; pfx_lock = 0; mod_f = '0;
    reg_f = '0; rm_f = '0; rex_r = 0; rex_b = 0; mode64 = 0; ea = '0;
    flags_in = 32'hA5A5_0F0F; rsp_valid = 0; rsp_fault = 0; rsp_data = '0; rd_idx = '0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_load64();
    t_load32();
    t_regmove();
    t_store64();
    t_store32();
    t_lock();
    t_index();
    t_fault();
    t_opcode();
    t_busy();
    t_flags();
    summary();
  end
endmodule